// File: doc/BRIEF.md
# Triggered Hit Pipeline With Derandomizer

This block takes one binary hit bit per strip channel on every clock edge and writes it into a circular delay store. The store keeps enough history that a trigger can still reach the slice taken a programmed number of clocks earlier. When a trigger arrives, the block gathers that slice together with the slice before it and the slice after it. These three slices form one frame, which goes into a small derandomizing queue. A downstream reader drains the queue at its own pace through a valid/ready port.

The input latch runs in one of two modes. In level mode a channel stores whatever its bit reads at the edge. In edge mode it stores a hit only when its bit has risen since the previous edge. Triggers have no back-pressure. A trigger that finds the queue full is dropped, and a saturating counter records the drop. On the read side a frame is transferred on every edge where `frame_valid_o` and `frame_ready_i` are both high. While the frame is held back, the data and the valid flag stay steady.

Top module: `hit_pipe`

## Requirements
- R1: In level mode (`edge_mode_i`=0), the sample stored for a channel at a clock edge equals `hit_i` at that edge.
- R2: In edge mode (`edge_mode_i`=1), a channel's stored sample is 1 only if `hit_i` is 1 at that edge and was 0 at the previous edge. The previous value counts as 0 right after reset, and it is tracked in both modes.
- R3: A trigger at edge n with effective latency L captures the frame {S[n-L+1], S[n-L], S[n-L-1]}. S[k] is the sample stored at edge k. The earliest bin sits in bits [N_CH-1:0], the central bin in [2*N_CH-1:N_CH] and the latest bin in [3*N_CH-1:2*N_CH]. The frame is readable after that edge.
- R4: The effective latency is `latency_i` clamped to the range 4..132. A smaller value acts as 4 and a larger value acts as 132.
- R5: Frames leave in trigger order. While `frame_valid_o` is high and `frame_ready_i` is low, `frame_valid_o` and `frame_data_o` hold.
- R6: `full_o` is high exactly when 8 frames are stored. A trigger at an edge where `full_o` is high is dropped, even if a frame is popped at that same edge.
- R7: `drop_count_o` rises by one for each dropped trigger and saturates at its all-ones value. It changes for nothing else.
- R8: `empty_o` and `frame_valid_o` show that no frame is stored. Asserting `frame_ready_i` while the queue is empty has no effect.
- R9: After reset, `empty_o` is 1, `full_o` is 0, `frame_valid_o` is 0 and `drop_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hit_i | input | N_CH (128) | Discriminator bit per channel |
| edge_mode_i | input | 1 | 1 selects edge mode, 0 selects level mode |
| trig_i | input | 1 | Trigger, at most one per clock |
| latency_i | input | LAT_W (8) | Trigger latency in clocks, clamped to 4..132 |
| frame_valid_o | output | 1 | A frame is available |
| frame_ready_i | input | 1 | Reader accepts the frame |
| frame_data_o | output | 3*N_CH (384) | Three-bin frame at the head of the queue |
| full_o | output | 1 | Queue holds 8 frames |
| empty_o | output | 1 | Queue holds no frame |
| drop_count_o | output | OVF_W (16) | Saturating count of dropped triggers |

## Verification
The queue assertions assume that the reader leaves `frame_ready_i` alone within a clock, and that triggers arrive as single-edge pulses. The bench drives every input at the falling edge, so each rising edge sees settled values. The frame bins are only defined once at least L+2 samples have been stored since reset. For that reason the bench starts with a 150-clock warm-up before its first trigger and keeps every trigger inside the filled history. The bench uses a small channel count and a 3-bit drop counter, so that saturation can be reached.

// File: rtl/hit_pipe_pkg.sv
package hit_pipe_pkg;
  localparam int HP_N_CH    = 128;
  localparam int HP_LAT_W   = 8;
  localparam int HP_LAT_MIN = 4;
  localparam int HP_LAT_MAX = 132;
  localparam int HP_QDEPTH  = 8;
  localparam int HP_OVF_W   = 16;

  typedef enum logic {
    LATCH_LEVEL = 1'b0,
    LATCH_EDGE  = 1'b1
  } latch_mode_e;
endpackage

// File: rtl/hit_pipe_sampler.sv
module hit_pipe_sampler
  import hit_pipe_pkg::*;
#(
  parameter int N_CH = HP_N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] hit_i,
  input  logic            edge_mode_i,
  output logic [N_CH-1:0] sample_o
);
  logic [N_CH-1:0] last_q;
  latch_mode_e     mode;

  assign mode = latch_mode_e'(edge_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= hit_i;
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    always_comb begin
      if (mode == LATCH_EDGE) sample_o[g] = hit_i[g] & ~last_q[g];
      else                    sample_o[g] = hit_i[g];
    end
  end
endmodule

// File: rtl/hit_pipe_ring.sv
module hit_pipe_ring
  import hit_pipe_pkg::*;
#(
  parameter int N_CH    = HP_N_CH,
  parameter int LAT_W   = HP_LAT_W,
  parameter int LAT_MIN = HP_LAT_MIN,
  parameter int LAT_MAX = HP_LAT_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   wr_data_i,
  input  logic [LAT_W-1:0]  latency_i,
  output logic [3*N_CH-1:0] window_o
);
  localparam int AW    = $clog2(LAT_MAX + 2);
  localparam int DEPTH = 1 << AW;

  logic [N_CH-1:0]  store [DEPTH];
  logic [AW-1:0]    wr_ptr_q;
  logic [AW-1:0]    rd_ptr;
  logic [LAT_W-1:0] lat_eff;

  always_comb begin
    if (latency_i < LAT_W'(LAT_MIN))      lat_eff = LAT_W'(LAT_MIN);
    else if (latency_i > LAT_W'(LAT_MAX)) lat_eff = LAT_W'(LAT_MAX);
    else                                  lat_eff = latency_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    store[wr_ptr_q] <= wr_data_i;
  end

  assign rd_ptr = wr_ptr_q - AW'(lat_eff);

  assign window_o = {store[rd_ptr + 1'b1], store[rd_ptr], store[rd_ptr - 1'b1]};
endmodule

// File: rtl/hit_pipe_fifo.sv
module hit_pipe_fifo
  import hit_pipe_pkg::*;
#(
  parameter int W     = 3 * HP_N_CH,
  parameter int DEPTH = HP_QDEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         empty_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign valid_o = !empty_o;
  assign do_push = push_i && !full_o;
  assign do_pop  = ready_i && !empty_o;
  assign data_o  = slots[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) slots[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: occupancy never passes the queue depth
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R6: a trigger on a full queue leaves it full when nothing is read
  p_full_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !ready_i) |=> full_o);

  // R5: a stalled frame holds its data and valid flag
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R8: reading an empty queue leaves it empty unless something is written
  p_empty_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/hit_pipe.sv
module hit_pipe
  import hit_pipe_pkg::*;
#(
  parameter int N_CH    = HP_N_CH,
  parameter int LAT_W   = HP_LAT_W,
  parameter int LAT_MIN = HP_LAT_MIN,
  parameter int LAT_MAX = HP_LAT_MAX,
  parameter int QDEPTH  = HP_QDEPTH,
  parameter int OVF_W   = HP_OVF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   hit_i,
  input  logic              edge_mode_i,
  input  logic              trig_i,
  input  logic [LAT_W-1:0]  latency_i,
  output logic              frame_valid_o,
  input  logic              frame_ready_i,
  output logic [3*N_CH-1:0] frame_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [OVF_W-1:0]  drop_count_o
);
  localparam int FW = 3 * N_CH;

  logic [N_CH-1:0] sample;
  logic [FW-1:0]   window;
  logic [OVF_W-1:0] drop_q;

  hit_pipe_sampler #(.N_CH(N_CH)) sampler_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit_i),
    .edge_mode_i(edge_mode_i), .sample_o(sample)
  );

  hit_pipe_ring #(.N_CH(N_CH), .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX)) ring_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_i(sample),
    .latency_i(latency_i), .window_o(window)
  );

  hit_pipe_fifo #(.W(FW), .DEPTH(QDEPTH)) fifo_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(trig_i), .data_i(window),
    .full_o(full_o), .empty_o(empty_o), .valid_o(frame_valid_o),
    .ready_i(frame_ready_i), .data_o(frame_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  drop_q <= '0;
    else if (trig_i && full_o && drop_q != '1)    drop_q <= drop_q + 1'b1;
  end

  assign drop_count_o = drop_q;

  // R7: a dropped trigger adds one to a non-saturated count
  p_drop_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && full_o && drop_count_o != '1) |=> drop_count_o == $past(drop_count_o) + 1'b1);

  // R7: without a dropped trigger the count holds
  p_drop_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trig_i && full_o) |=> $stable(drop_count_o));
endmodule

// File: tb/hit_pipe_tb_top.sv
module hit_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int FW    = 3 * N;
  localparam int OVF_W = 3;
  localparam int QD    = 8;
  localparam int LMIN  = 4;
  localparam int LMAX  = 132;
  localparam int OMAX  = (1 << OVF_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hit = '0;
  logic edge_mode = 1'b0;
  logic trig = 1'b0;
  logic [7:0] latency = 8'd4;
  logic frame_valid, frame_ready = 1'b0;
  logic [FW-1:0] frame_data;
  logic full, empty;
  logic [OVF_W-1:0] drop_count;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hit_pipe #(.N_CH(N), .LAT_W(8), .LAT_MIN(LMIN), .LAT_MAX(LMAX), .QDEPTH(QD), .OVF_W(OVF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .edge_mode_i(edge_mode),
    .trig_i(trig), .latency_i(latency), .frame_valid_o(frame_valid),
    .frame_ready_i(frame_ready), .frame_data_o(frame_data),
    .full_o(full), .empty_o(empty), .drop_count_o(drop_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int ovf_exp = 0;
  bit done = 0;
  string tag = "R9";
  logic [N-1:0] s_hist [0:8191];
  logic [N-1:0] prev_h = '0;
  logic [FW-1:0] mq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_outputs();
    chk(frame_valid == (mq.size() > 0), "R5", "valid", 64'(frame_valid), 64'(mq.size() > 0));
    chk(empty == (mq.size() == 0), "R8", "empty", 64'(empty), 64'(mq.size() == 0));
    chk(full == (mq.size() == QD), "R6", "full", 64'(full), 64'(mq.size() == QD));
    chk(int'(drop_count) == ovf_exp, "R7", "drop count", 64'(drop_count), 64'(ovf_exp));
    if (mq.size() > 0)
      chk(frame_data == mq[0], tag, "frame", 64'(frame_data), 64'(mq[0]));
  endtask

  function automatic int clamp_lat(input int l);
    int v = l & 255;
    if (v < LMIN) return LMIN;
    if (v > LMAX) return LMAX;
    return v;
  endfunction

  // Called at a falling edge: check, drive, advance the model, pass one rising edge.
  task automatic step(input logic [N-1:0] h, input bit em, input bit tr, input int lat, input bit rdy);
    logic [N-1:0] s;
    logic [FW-1:0] fr;
    bit do_pop, do_push;
    int le;
    check_outputs();
    hit = h; edge_mode = em; trig = tr; latency = lat[7:0]; frame_ready = rdy;
    s = em ? (h & ~prev_h) : h;
    s_hist[cyc] = s;
    prev_h = h;
    do_pop = rdy && (mq.size() > 0);
    do_push = 0;
    fr = '0;
    if (tr) begin
      le = clamp_lat(lat);
      fr = {s_hist[cyc - le + 1], s_hist[cyc - le], s_hist[cyc - le - 1]};
      if (mq.size() < QD) do_push = 1;
      else if (ovf_exp < OMAX) ovf_exp++;
    end
    if (do_pop) void'(mq.pop_front());
    if (do_push) mq.push_back(fr);
    cyc++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    chk(empty == 1'b1, "R9", "empty after reset", 64'(empty), 64'd1);
    chk(full == 1'b0, "R9", "full after reset", 64'(full), 64'd0);
    chk(frame_valid == 1'b0, "R9", "valid after reset", 64'(frame_valid), 64'd0);
    chk(drop_count == '0, "R9", "drop count after reset", 64'(drop_count), 64'd0);

    // R1: level mode, history warm-up then triggers at mixed latencies
    tag = "R1";
    for (int k = 0; k < 300; k++)
      step(N'($urandom), 1'b0, (k >= 150) && (k % 5 == 0), LMIN + (k % 20), (k % 3) != 0);

    // R2: edge mode, then mode toggled every clock
    tag = "R2";
    for (int k = 0; k < 200; k++)
      step(N'($urandom), 1'b1, (k % 4 == 0), LMIN + (k % 129), 1'b1);
    for (int k = 0; k < 200; k++)
      step(N'($urandom), k[0], (k % 3 == 0), LMIN + ((k * 7) % 129), (k % 2) == 0);
    for (int k = 0; k < 10; k++) step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b1);

    // R4: sweep every latency code, including the clamped ones
    tag = "R4";
    for (int l = 0; l < 256; l++) begin
      step(N'($urandom), l[1], 1'b1, l, 1'b1);
      step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b1);
    end
    for (int k = 0; k < 4; k++) step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b1);

    // R3: back-to-back triggers at the longest latency
    tag = "R3";
    for (int k = 0; k < 40; k++)
      step(N'($urandom), 1'b0, (k < 6) || (k % 4 == 0), LMAX, (k % 2) == 1);
    for (int k = 0; k < 12; k++) step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b1);

    // R6: fill with no reader, triggers beyond 8 are dropped
    tag = "R6";
    for (int k = 0; k < 12; k++) step(N'($urandom), 1'b0, 1'b1, 10 + k, 1'b0);
    // R6: trigger while full with a pop at the same edge is still dropped
    step(N'($urandom), 1'b0, 1'b1, 20, 1'b1);
    // R5: stall, data must hold
    tag = "R5";
    for (int k = 0; k < 4; k++) step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b0);
    // R7: drive the count into saturation
    tag = "R7";
    for (int k = 0; k < 6; k++) step(N'($urandom), 1'b0, 1'b1, 30, 1'b0);
    // R8: drain, then keep reading an empty queue
    tag = "R8";
    for (int k = 0; k < 16; k++) step(N'($urandom), 1'b0, 1'b0, LMIN, 1'b1);
    check_outputs();
    finish_run();
  end
endmodule